// File: doc/BRIEF.md
# Two-Tier Round-Robin Bus Arbiter

This block decides which agent may drive a shared parallel bus segment. Six external masters each raise an active-low request line and receive an active-low grant line with the same index. The bridge that hosts the arbiter takes part as a seventh agent through an active-high request and grant pair. A grant tells its agent that it may start a transaction on the bus. The lock line of the bus is not an input: only the request lines take part in the decision.

Each agent is set to the high or the low tier by a configuration bit. The high tier rotates round robin over the high agents plus one extra slot that stands for the whole low tier. When that slot wins, a second round-robin pointer picks the next low agent. A hold timer lets the current owner keep its grant across back-to-back transactions while other agents wait. When the bus has no requests, the grant parks either on the last owner or on the bridge. The tier bits, the timer reload value and the parking mode are captured only in cycles where the bus is idle.

Top module: `tiered_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, all `gnt_n` bits are 1 and `int_gnt` is 0. At the third edge with no requests, the bridge is granted (`int_gnt` = 1). External agent i requests with `req_n[i]` = 0, and is granted with `gnt_n[i]` = 0.
- R2: At most one grant, counting the six external grants and `int_gnt`, is active in any cycle.
- R3: A grant goes away for at least one cycle with no grant active before a different agent is granted.
- R4: High-tier agents are served round robin. Agent i is the bridge when i = 6. The rotation order is 0..6, followed by the low-tier slot at position 7. The search starts one position after the last high-tier winner, and starts at 0 after the slot wins.
- R5: When the low-tier slot wins, the low-tier agent is chosen round robin over agents 0..6. The search starts one position after the previous low-tier winner. An agent is in the low tier when its `cfg_hi_tier` bit is 0.
- R6: Each grant loads the hold timer from `cfg_hold_cnt`. The timer counts down by one in every cycle where the owner keeps the grant and `bus_idle` is 0, and it stops at zero.
- R7: An owner that keeps its request asserted keeps the grant while the timer is nonzero, even when other agents are requesting. The grant is removed at the first edge where the timer is zero and another agent requests.
- R8: When the owner drops its request and another agent is requesting, the grant is removed at the next edge.
- R9: With `cfg_park_last` = 1 and no requests, the last owner keeps its grant, or gets it back if no agent holds a grant.
- R10: With `cfg_park_last` = 0 and no requests, a non-bridge owner loses its grant, and the bridge is granted one cycle later.
- R11: The tier bits, the reload value and the parking mode are captured at an edge only when `bus_idle` is 1. The decision at that edge still uses the previously captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| req_n | input | 6 | External requests, active low, index i belongs to agent i |
| int_req | input | 1 | Bridge request, active high |
| bus_idle | input | 1 | 1 when no transaction is in progress on the bus |
| cfg_hi_tier | input | 7 | Tier bit per agent (bit 6 = bridge), 1 = high tier |
| cfg_hold_cnt | input | 8 | Hold timer reload value |
| cfg_park_last | input | 1 | 1 = park on the last owner, 0 = park on the bridge |
| gnt_n | output | 6 | External grants, active low, at most one low |
| int_gnt | output | 1 | Bridge grant, active high |

## Verification
The bench follows one thread of traffic that reaches every corner case. It counts the exact edge where an expiring hold timer gives way to a waiting agent. A design that dropped the grant one cycle early or late, or that counted down while the bus was idle, would move the grant in the wrong cycle. It checks that a low-tier agent with a higher index is served before one with a lower index when the low pointer says so, and that the pointers wrap between tiers; a flat rotation would pick the wrong agent. It also changes the parking mode while the bus is busy, where a design that captured configuration without waiting for an idle bus would hand the grant to the bridge too early. Every grant change is checked for the one-cycle gap with no grant active.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Action chosen by the arbiter in one cycle.
  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,  // current owner keeps the bus
    ACT_DROP = 2'd1,  // grant removed, bus left without owner for a cycle
    ACT_ARB  = 2'd2,  // new owner chosen from pending requests
    ACT_PARK = 2'd3   // no requests: idle grant placed by parking policy
  } arb_act_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Round-robin search: first set bit of req at or after ptr, wrapping.
module arb_rr_pick #(
  parameter int W  = 8,
  parameter int PW = 3
) (
  input  logic [W-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          found,
  output logic [PW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < W; k++) begin
      int pos;
      pos = int'(ptr) + k;
      if (pos >= W) pos = pos - W;
      if (!found && req[pos]) begin
        found = 1'b1;
        idx   = PW'(pos);
      end
    end
  end

endmodule

// File: rtl/arb_tier_sel.sv
// Two-tier selection: the low tier is one slot (index N_AG) in the high rotation.
module arb_tier_sel #(
  parameter int N_AG = 7,
  parameter int PW   = 3
) (
  input  logic [N_AG-1:0] req,
  input  logic [N_AG-1:0] hi_mask,
  input  logic [PW-1:0]   hi_ptr,
  input  logic [PW-1:0]   lo_ptr,
  output logic            found,
  output logic [PW-1:0]   win,
  output logic [PW-1:0]   hi_ptr_nxt,
  output logic [PW-1:0]   lo_ptr_nxt
);

  localparam logic [PW-1:0] SLOT    = PW'(N_AG);
  localparam logic [PW-1:0] LO_LAST = PW'(N_AG - 1);

  logic [N_AG:0]   hi_cand;
  logic [N_AG-1:0] lo_cand;
  logic            hi_found, lo_found, slot_won;
  logic [PW-1:0]   hi_idx, lo_idx;

  assign lo_cand = req & ~hi_mask;
  assign hi_cand = {|lo_cand, req & hi_mask};

  arb_rr_pick #(.W(N_AG + 1), .PW(PW)) u_hi_pick (
    .req(hi_cand), .ptr(hi_ptr), .found(hi_found), .idx(hi_idx)
  );

  arb_rr_pick #(.W(N_AG), .PW(PW)) u_lo_pick (
    .req(lo_cand), .ptr(lo_ptr), .found(lo_found), .idx(lo_idx)
  );

  always_comb begin
    slot_won   = hi_found && (hi_idx == SLOT) && lo_found;
    found      = hi_found;
    win        = slot_won ? lo_idx : hi_idx;
    hi_ptr_nxt = hi_ptr;
    lo_ptr_nxt = lo_ptr;
    if (slot_won) begin
      hi_ptr_nxt = '0;
      lo_ptr_nxt = (lo_idx == LO_LAST) ? '0 : lo_idx + PW'(1);
    end else if (hi_found) begin
      hi_ptr_nxt = hi_idx + PW'(1);
    end
  end

endmodule

// File: rtl/arb_hold_timer.sv
// Hold timer: reload on grant, count busy cycles down to zero.
module arb_hold_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          busy,
  output logic          expired
);

  logic [TW-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (load)                         count_d = load_val;
    else if (busy && count_q != '0)   count_d = count_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign expired = (count_q == '0);

  // R6: a grant reloads the count
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_q == $past(load_val));

  // R6: busy cycles count down by one
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && count_q != '0) |=> count_q == $past(count_q) - TW'(1));

endmodule

// File: rtl/tiered_bus_arbiter.sv
module tiered_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_EXT = 6,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] req_n,
  input  logic             int_req,
  input  logic             bus_idle,
  input  logic [N_EXT:0]   cfg_hi_tier,
  input  logic [TMR_W-1:0] cfg_hold_cnt,
  input  logic             cfg_park_last,
  output logic [N_EXT-1:0] gnt_n,
  output logic             int_gnt
);

  localparam int N_AG = N_EXT + 1;
  localparam int PW   = $clog2(N_AG + 1);
  localparam logic [PW-1:0] BRIDGE = PW'(N_EXT);

  // reset synchronizer: asynchronous assert, synchronous release
  logic rs_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rs_meta} <= 2'b00;
    else        {rst_s, rs_meta} <= {rs_meta, 1'b1};
  end

  // configuration captured only while bus is idle
  logic [N_AG-1:0]  hi_q;
  logic [TMR_W-1:0] hold_q;
  logic             park_q;
  logic             cfg_en;
  assign cfg_en = bus_idle;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      hi_q   <= '0;
      hold_q <= '0;
      park_q <= 1'b0;
    end else if (cfg_en) begin
      hi_q   <= cfg_hi_tier;
      hold_q <= cfg_hold_cnt;
      park_q <= cfg_park_last;
    end
  end

  // arbitration state
  logic [N_AG-1:0] gnt_q, gnt_d;
  logic [PW-1:0]   owner_q, owner_d;
  logic [PW-1:0]   hp_q, hp_d, lp_q, lp_d;

  logic [N_AG-1:0] req_v;
  logic            granted, own_req, others, expired;
  logic            sel_found;
  logic [PW-1:0]   sel_win, sel_hp, sel_lp, park_tgt;
  arb_act_e        act;

  assign req_v   = {int_req, ~req_n};
  assign granted = |gnt_q;
  assign own_req = |(req_v & gnt_q);
  assign others  = |(req_v & ~gnt_q);

  arb_tier_sel #(.N_AG(N_AG), .PW(PW)) u_tier_sel (
    .req        (req_v),
    .hi_mask    (hi_q),
    .hi_ptr     (hp_q),
    .lo_ptr     (lp_q),
    .found      (sel_found),
    .win        (sel_win),
    .hi_ptr_nxt (sel_hp),
    .lo_ptr_nxt (sel_lp)
  );

  arb_hold_timer #(.TW(TMR_W)) u_hold_timer (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     ((act == ACT_ARB) || (act == ACT_PARK)),
    .load_val (hold_q),
    .busy     ((act == ACT_KEEP) && !bus_idle),
    .expired  (expired)
  );

  // action decode
  always_comb begin
    act = ACT_KEEP;
    if (granted) begin
      if (others && (!own_req || expired))
        act = ACT_DROP;
      else if (!others && !own_req && !park_q && !gnt_q[N_EXT])
        act = ACT_DROP;
    end else if (sel_found) begin
      act = ACT_ARB;
    end else begin
      act = ACT_PARK;
    end
  end

  assign park_tgt = park_q ? owner_q : BRIDGE;

  // next state
  always_comb begin
    gnt_d   = gnt_q;
    owner_d = owner_q;
    hp_d    = hp_q;
    lp_d    = lp_q;
    case (act)
      ACT_DROP: gnt_d = '0;
      ACT_ARB: begin
        gnt_d   = N_AG'(1) << sel_win;
        owner_d = sel_win;
        hp_d    = sel_hp;
        lp_d    = sel_lp;
      end
      ACT_PARK: begin
        gnt_d   = N_AG'(1) << park_tgt;
        owner_d = park_tgt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      gnt_q   <= '0;
      owner_q <= BRIDGE;
      hp_q    <= '0;
      lp_q    <= '0;
    end else begin
      gnt_q   <= gnt_d;
      owner_q <= owner_d;
      hp_q    <= hp_d;
      lp_q    <= lp_d;
    end
  end

  assign gnt_n   = ~gnt_q[N_EXT-1:0];
  assign int_gnt = gnt_q[N_EXT];

  // R2: never two grants
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(gnt_q));

  // R3: an active grant either stays put or is removed first
  p_idle_gap_r3: assert property (@(posedge clk) disable iff (!rst_s)
    granted |=> (gnt_q == $past(gnt_q)) || (gnt_q == '0));

  // R7: requesting owner with time left keeps the bus
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (granted && own_req && !expired) |=> gnt_q == $past(gnt_q));

  // R10: idle bus with bridge parking grants the bridge
  p_park_bridge_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (!granted && !(|req_v) && !park_q) |=> gnt_q[N_EXT]);

  // R11: configuration frozen across busy cycles
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_s)
    !bus_idle |=> $stable(hi_q) && $stable(hold_q) && $stable(park_q));

endmodule

// File: tb/tiered_bus_arbiter_bench.sv
module tiered_bus_arbiter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] req_n;
  logic       int_req;
  logic       bus_idle;
  logic [6:0] cfg_hi_tier;
  logic [7:0] cfg_hold_cnt;
  logic       cfg_park_last;
  logic [5:0] gnt_n;
  logic       int_gnt;

  int    errors = 0;
  int    checks = 0;
  bit    done   = 1'b0;
  string cur_tag = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  tiered_bus_arbiter u_tiered_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .int_req(int_req),
    .bus_idle(bus_idle), .cfg_hi_tier(cfg_hi_tier), .cfg_hold_cnt(cfg_hold_cnt),
    .cfg_park_last(cfg_park_last), .gnt_n(gnt_n), .int_gnt(int_gnt)
  );

  // ---------------- behavioural reference model ----------------
  int       m_gnt;   // -1 = nobody, 0..6 = agent (6 = bridge)
  int       m_own, m_t, m_hp, m_lp, m_mtt;
  bit       m_park;
  bit [6:0] m_hi;
  bit       m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0;
      m_gnt = -1; m_own = 6; m_t = 0; m_hp = 0; m_lp = 0;
      m_mtt = 0; m_park = 0; m_hi = '0;
    end else begin
      bit live;
      bit [6:0] r;
      live = m_s2;
      m_s2 = m_s1;
      m_s1 = 1;
      r = {int_req, ~req_n};
      if (live) begin
        if (m_gnt >= 0) begin
          bit own, oth;
          own = r[m_gnt];
          oth = (r & ~(7'd1 << m_gnt)) != 0;
          if (oth && (!own || m_t == 0)) m_gnt = -1;
          else if (!oth && !own && !m_park && m_gnt != 6) m_gnt = -1;
          else if (!bus_idle && m_t > 0) m_t = m_t - 1;
        end else if (r != 0) begin
          int win;
          win = -1;
          for (int k = 0; k < 8; k++) begin
            int p;
            p = (m_hp + k) % 8;
            if (win < 0) begin
              if (p < 7 && m_hi[p] && r[p]) begin
                win = p; m_hp = p + 1;
              end else if (p == 7 && (r & ~m_hi) != 0) begin
                for (int j = 0; j < 7; j++) begin
                  int q;
                  q = (m_lp + j) % 7;
                  if (win < 0 && !m_hi[q] && r[q]) begin
                    win = q; m_lp = (q + 1) % 7; m_hp = 0;
                  end
                end
              end
            end
          end
          m_gnt = win; m_own = win; m_t = m_mtt;
        end else begin
          m_gnt = m_park ? m_own : 6;
          m_own = m_gnt; m_t = m_mtt;
        end
        if (bus_idle) begin
          m_hi = cfg_hi_tier; m_mtt = int'(cfg_hold_cnt); m_park = cfg_park_last;
        end
      end
    end
  end

  function automatic bit [6:0] grant_vec(int a);
    grant_vec = (a < 0) ? 7'h7f : ~(7'd1 << a);
  endfunction

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit [6:0] act_v, exp_v;
      act_v = {~int_gnt, gnt_n};
      exp_v = grant_vec(m_gnt);
      checks++;
      if (act_v !== exp_v) begin
        errors++;
        $display("FAIL %s (model cycle): grants actual=%b expected=%b", cur_tag, act_v, exp_v);
      end
    end
  end

  // directed check with a hand-computed owner (-1 = none)
  task automatic expect_agent(string tag, int a);
    bit [6:0] act_v, exp_v;
    act_v = {~int_gnt, gnt_n};
    exp_v = grant_vec(a);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: grants actual=%b expected=%b", tag, act_v, exp_v);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_req(bit [5:0] ext, bit br);
    req_n   = ~ext;
    int_req = br;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_n = '1; int_req = 0; bus_idle = 1;
    cfg_hi_tier = 7'h7f; cfg_hold_cnt = 8'd4; cfg_park_last = 0;
    step(3);
    expect_agent("R1 in reset", -1);
    rst_n = 1;
    step(2); expect_agent("R1 sync hold", -1);
    step(1); expect_agent("R1 first park on bridge", 6);

    cur_tag = "R8";
    set_req(6'b000100, 0);
    step(1); expect_agent("R8 bridge released", -1);
    step(1); expect_agent("R4 agent 2 granted", 2);

    cur_tag = "R7";
    bus_idle = 0; set_req(6'b010100, 0);
    step(4); expect_agent("R7 owner holds while timer runs", 2);
    step(1); expect_agent("R3 gap after timer expiry", -1);
    step(1); expect_agent("R7 waiting agent 4 granted", 4);

    cur_tag = "R4";
    bus_idle = 1; set_req(6'b101010, 0);
    step(2); expect_agent("R4 rotation picks 5", 5);
    set_req(6'b001010, 0);
    step(2); expect_agent("R4 rotation wraps to 1", 1);
    set_req(6'b001000, 0);
    step(2); expect_agent("R4 rotation picks 3", 3);

    cur_tag = "R10";
    set_req(6'b000000, 0);
    step(1); expect_agent("R10 non-bridge owner released", -1);
    step(1); expect_agent("R10 parked on bridge", 6);

    cur_tag = "R9";
    cfg_park_last = 1; set_req(6'b000001, 0);
    step(2); expect_agent("R9 agent 0 granted", 0);
    set_req(6'b000000, 0);
    step(3); expect_agent("R9 parked on last owner", 0);
    set_req(6'b000010, 0);
    step(1); expect_agent("R3 gap before agent 1", -1);
    step(1); expect_agent("R9 agent 1 granted", 1);

    cur_tag = "R5";
    cfg_hi_tier = 7'b1111000; set_req(6'b100101, 0);
    step(2); expect_agent("R5 high agent 5 first", 5);
    set_req(6'b000101, 0);
    step(2); expect_agent("R5 low slot picks 0", 0);
    set_req(6'b100100, 0);
    step(2); expect_agent("R5 slot resets high pointer, 5", 5);
    set_req(6'b000101, 0);
    step(2); expect_agent("R5 low pointer advanced to 2", 2);

    cur_tag = "R11";
    bus_idle = 0; cfg_park_last = 0; set_req(6'b000000, 0);
    step(3); expect_agent("R11 park mode change ignored while busy", 2);
    bus_idle = 1;
    step(1); expect_agent("R11 old mode used at capture edge", 2);
    step(1); expect_agent("R11 new mode releases owner", -1);
    step(1); expect_agent("R11 bridge parked after capture", 6);

    cur_tag = "R6";
    bus_idle = 0; set_req(6'b001000, 1);
    step(4); expect_agent("R6 bridge holds for reload count", 6);
    step(1); expect_agent("R6 bridge released at expiry", -1);
    step(1); expect_agent("R2 agent 3 granted alone", 3);

    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule